// File: doc/BRIEF.md
# Virtual Process Route Translator

This block turns a virtual process number, presented together with the number of the context that issues it, into the information needed to send a message: the route bytes that steer the packet to the destination processor, and the context to deliver into at the far end. User code never sees a physical processor identity; it names peers only by virtual process number.

The lookup has two levels. The context number selects a per-context table of virtual process entries; each entry holds a valid bit, a destination context and an index into a shared routing table. That index then selects a routing table entry holding the route bytes and a live bit. Checking and translation happen in the same lookup. If the context is out of range or disabled, the entry is invalid, or the routing entry is not live, the response carries a permission exception instead of a translation. Clearing one routing entry's live bit takes a failed processor out of service for every context at once.

Requests and responses use valid/ready handshakes, with a fixed two-cycle latency when the response side is ready. A host-side write port loads context enables, virtual process entries, route bytes and live bits.

Top module: `vproc_xlate`

## Requirements
- R1: After reset every context enable, entry valid bit and route live bit is clear; no response is pending; `req_ready` is 1; and the first request after reset gets an exception.
- R2: A request accepted in cycle t (`req_valid` and `req_ready` both 1) produces `resp_valid` in cycle t+2 when `resp_ready` is 1 in cycle t+1. Back-to-back requests get back-to-back responses.
- R3: If the context is enabled, the entry is valid and its routing entry is live, the response has `resp_ok`=1, `resp_exc`=0, `resp_route` equal to the stored route bytes and `resp_dctx` equal to the entry's destination context.
- R4: A context number of NUM_CTX (16) or more gets an exception.
- R5: A request from a context whose enable bit is clear gets an exception.
- R6: A request whose virtual process entry is invalid gets an exception. Clearing an entry's valid bit denies the next request accepted after the write.
- R7: A request whose entry points at a routing entry with a clear live bit gets an exception. This holds for every context that points there, and setting the bit again restores translation.
- R8: An exception response has `resp_ok`=0, `resp_exc`=1, and both `resp_route` and `resp_dctx` equal to zero.
- R9: While `resp_valid` is 1 and `resp_ready` is 0, the response holds stable and `req_ready` is 0.
- R10: The write port acts on the rising edge at which `wr_en` is 1, selected by `wr_kind`. Kind 0 sets the enable of context `wr_ctx` to `wr_data[0]`. Kind 1 writes entry (`wr_ctx`, `wr_idx`) with valid=`wr_data[31]`, routing index=`wr_data[13:8]` and destination context=`wr_data[7:0]`. Kind 2 writes the route bytes of routing entry `wr_idx` from `wr_data`. Kind 3 sets that routing entry's live bit to `wr_data[0]`. Writes of kind 0 or 1 with an out-of-range `wr_ctx` are dropped.
- R11: A request accepted in the same cycle as a kind 0 or kind 1 write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_ctx | input | 5 | Requesting context number |
| req_vp | input | 6 | Virtual process number |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response consumed this cycle when high |
| resp_ok | output | 1 | Translation valid |
| resp_exc | output | 1 | Permission exception |
| resp_route | output | 32 | Route bytes to the destination processor |
| resp_dctx | output | 8 | Destination context |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | Write target: 0 context enable, 1 entry, 2 route bytes, 3 live bit |
| wr_ctx | input | 5 | Context number for kinds 0 and 1 |
| wr_idx | input | 6 | Entry number (kind 1) or routing index (kinds 2, 3) |
| wr_data | input | 32 | Write payload |

## Verification
Assertions check on every cycle the two-cycle request-to-response timing, response stability under backpressure, the zeroed payload of every exception response, the exception for out-of-range contexts, and that clearing a context enable or a live bit denies the very next lookup. Only the bench scenarios can show that the right route bytes and destination context come back for each context and entry pair. The same goes for revoking a shared routing entry, which denies several contexts together and can be undone, and for the rule that a write in the acceptance cycle leaves that request on the old contents.

// File: rtl/vproc_xlate_pkg.sv
package vproc_xlate_pkg;

  // Host write targets
  typedef enum logic [1:0] {
    WK_CTX_EN     = 2'd0,
    WK_VP_ENTRY   = 2'd1,
    WK_ROUTE_DATA = 2'd2,
    WK_ROUTE_LIVE = 2'd3
  } wr_kind_e;

endpackage

// File: rtl/vproc_ctx_store.sv
// Context enables plus per-context virtual process entries; combinational read.
module vproc_ctx_store #(
  parameter int NUM_CTX  = 16,
  parameter int NUM_VP   = 64,
  parameter int CTX_IN_W = 5,
  parameter int RIDX_W   = 6,
  parameter int DCTX_W   = 8,
  localparam int CTX_W   = $clog2(NUM_CTX),
  localparam int VP_W    = $clog2(NUM_VP),
  localparam int FLAT_W  = CTX_W + VP_W,
  localparam int ENTRIES = NUM_CTX * NUM_VP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_ctx,
  input  logic                we_entry,
  input  logic [CTX_IN_W-1:0] w_ctx,
  input  logic [VP_W-1:0]     w_vp,
  input  logic                w_en_bit,
  input  logic                w_vld_bit,
  input  logic [RIDX_W-1:0]   w_ridx,
  input  logic [DCTX_W-1:0]   w_dctx,
  input  logic [CTX_IN_W-1:0] rd_ctx,
  input  logic [VP_W-1:0]     rd_vp,
  output logic                rd_hit,
  output logic [RIDX_W-1:0]   rd_ridx,
  output logic [DCTX_W-1:0]   rd_dctx
);

  logic                w_in_range;
  logic                rd_in_range;
  logic [FLAT_W-1:0]   w_flat;
  logic [FLAT_W-1:0]   rd_flat;

  logic                en_q   [NUM_CTX];
  logic                en_d   [NUM_CTX];
  logic                vld_q  [ENTRIES];
  logic                vld_d  [ENTRIES];
  logic [RIDX_W-1:0]   ridx_q [ENTRIES];
  logic [DCTX_W-1:0]   dctx_q [ENTRIES];

  assign w_in_range  = {1'b0, w_ctx}  < (CTX_IN_W+1)'(NUM_CTX);
  assign rd_in_range = {1'b0, rd_ctx} < (CTX_IN_W+1)'(NUM_CTX);
  assign w_flat      = {w_ctx[CTX_W-1:0], w_vp};
  assign rd_flat     = {rd_ctx[CTX_W-1:0], rd_vp};

  // Next state of the enable and valid bits
  always_comb begin
    for (int c = 0; c < NUM_CTX; c++) en_d[c] = en_q[c];
    for (int e = 0; e < ENTRIES; e++) vld_d[e] = vld_q[e];
    if (we_ctx && w_in_range)   en_d[w_ctx[CTX_W-1:0]] = w_en_bit;
    if (we_entry && w_in_range) vld_d[w_flat]          = w_vld_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CTX; c++) en_q[c] <= 1'b0;
      for (int e = 0; e < ENTRIES; e++) vld_q[e] <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_CTX; c++) en_q[c] <= en_d[c];
      for (int e = 0; e < ENTRIES; e++) vld_q[e] <= vld_d[e];
    end
  end

  // Entry payload: clock-enabled storage, no reset
  always_ff @(posedge clk) begin
    if (we_entry && w_in_range) begin
      ridx_q[w_flat] <= w_ridx;
      dctx_q[w_flat] <= w_dctx;
    end
  end

  assign rd_hit  = rd_in_range && en_q[rd_ctx[CTX_W-1:0]] && vld_q[rd_flat];
  assign rd_ridx = ridx_q[rd_flat];
  assign rd_dctx = dctx_q[rd_flat];

  // R5: a context disabled on the previous edge cannot hit now
  a_r5_disable_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we_ctx && w_in_range && !w_en_bit) && rd_ctx == $past(w_ctx)) |-> !rd_hit);

  // R6: an entry invalidated on the previous edge cannot hit now
  a_r6_invalidate_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we_entry && w_in_range && !w_vld_bit) && rd_ctx == $past(w_ctx)
     && rd_vp == $past(w_vp)) |-> !rd_hit);

endmodule

// File: rtl/vproc_route_store.sv
// Shared routing table: route bytes plus a live bit per entry.
module vproc_route_store #(
  parameter int NUM_ROUTE   = 64,
  parameter int ROUTE_BYTES = 4,
  localparam int RIDX_W     = $clog2(NUM_ROUTE),
  localparam int ROUTE_W    = 8 * ROUTE_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_data,
  input  logic               we_live,
  input  logic [RIDX_W-1:0]  w_idx,
  input  logic [ROUTE_W-1:0] w_data,
  input  logic               w_live,
  input  logic [RIDX_W-1:0]  rd_idx,
  output logic [ROUTE_W-1:0] rd_route,
  output logic               rd_live
);

  logic               live_q [NUM_ROUTE];
  logic               live_d [NUM_ROUTE];
  logic [ROUTE_W-1:0] route_q [NUM_ROUTE];

  always_comb begin
    for (int r = 0; r < NUM_ROUTE; r++) live_d[r] = live_q[r];
    if (we_live) live_d[w_idx] = w_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROUTE; r++) live_q[r] <= 1'b0;
    end else begin
      for (int r = 0; r < NUM_ROUTE; r++) live_q[r] <= live_d[r];
    end
  end

  // Route bytes stored lane by lane, each lane clock-enabled
  for (genvar b = 0; b < ROUTE_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we_data) route_q[w_idx][8*b +: 8] <= w_data[8*b +: 8];
    end
  end

  assign rd_route = route_q[rd_idx];
  assign rd_live  = live_q[rd_idx];

  // R7: a routing entry marked dead on the previous edge reads as not live
  a_r7_revoke_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we_live && !w_live) && rd_idx == $past(w_idx)) |-> !rd_live);

endmodule

// File: rtl/vproc_xlate.sv
module vproc_xlate
  import vproc_xlate_pkg::*;
#(
  parameter int NUM_CTX     = 16,
  parameter int NUM_VP      = 64,
  parameter int NUM_ROUTE   = 64,
  parameter int ROUTE_BYTES = 4,
  parameter int DCTX_W      = 8,
  parameter int CTX_IN_W    = 5,
  localparam int VP_W       = $clog2(NUM_VP),
  localparam int RIDX_W     = $clog2(NUM_ROUTE),
  localparam int ROUTE_W    = 8 * ROUTE_BYTES,
  localparam int WIDX_W     = (VP_W > RIDX_W) ? VP_W : RIDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CTX_IN_W-1:0] req_ctx,
  input  logic [VP_W-1:0]     req_vp,
  output logic                resp_valid,
  input  logic                resp_ready,
  output logic                resp_ok,
  output logic                resp_exc,
  output logic [ROUTE_W-1:0]  resp_route,
  output logic [DCTX_W-1:0]   resp_dctx,
  input  logic                wr_en,
  input  logic [1:0]          wr_kind,
  input  logic [CTX_IN_W-1:0] wr_ctx,
  input  logic [WIDX_W-1:0]   wr_idx,
  input  logic [ROUTE_W-1:0]  wr_data
);

  localparam int VLD_BIT = ROUTE_W - 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Write decode
  wr_kind_e wk;
  logic     we_ctx, we_entry, we_rdata, we_rlive;

  assign wk       = wr_kind_e'(wr_kind);
  assign we_ctx   = wr_en && (wk == WK_CTX_EN);
  assign we_entry = wr_en && (wk == WK_VP_ENTRY);
  assign we_rdata = wr_en && (wk == WK_ROUTE_DATA);
  assign we_rlive = wr_en && (wk == WK_ROUTE_LIVE);

  // First level: context and virtual process entry
  logic              lk_hit;
  logic [RIDX_W-1:0] lk_ridx;
  logic [DCTX_W-1:0] lk_dctx;

  vproc_ctx_store #(
    .NUM_CTX (NUM_CTX),
    .NUM_VP  (NUM_VP),
    .CTX_IN_W(CTX_IN_W),
    .RIDX_W  (RIDX_W),
    .DCTX_W  (DCTX_W)
  ) u_ctx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .we_ctx   (we_ctx),
    .we_entry (we_entry),
    .w_ctx    (wr_ctx),
    .w_vp     (wr_idx[VP_W-1:0]),
    .w_en_bit (wr_data[0]),
    .w_vld_bit(wr_data[VLD_BIT]),
    .w_ridx   (wr_data[DCTX_W +: RIDX_W]),
    .w_dctx   (wr_data[DCTX_W-1:0]),
    .rd_ctx   (req_ctx),
    .rd_vp    (req_vp),
    .rd_hit   (lk_hit),
    .rd_ridx  (lk_ridx),
    .rd_dctx  (lk_dctx)
  );

  // Stage 1 registers
  logic              s1_v_q,    s1_v_d;
  logic              s1_hit_q,  s1_hit_d;
  logic [RIDX_W-1:0] s1_ridx_q, s1_ridx_d;
  logic [DCTX_W-1:0] s1_dctx_q, s1_dctx_d;

  // Second level: routing table
  logic [ROUTE_W-1:0] rt_route;
  logic               rt_live;

  vproc_route_store #(
    .NUM_ROUTE  (NUM_ROUTE),
    .ROUTE_BYTES(ROUTE_BYTES)
  ) u_route (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we_data (we_rdata),
    .we_live (we_rlive),
    .w_idx   (wr_idx[RIDX_W-1:0]),
    .w_data  (wr_data),
    .w_live  (wr_data[0]),
    .rd_idx  (s1_ridx_q),
    .rd_route(rt_route),
    .rd_live (rt_live)
  );

  // Stage 2 registers
  logic               s2_v_q,     s2_v_d;
  logic               s2_ok_q,    s2_ok_d;
  logic [ROUTE_W-1:0] s2_route_q, s2_route_d;
  logic [DCTX_W-1:0]  s2_dctx_q,  s2_dctx_d;

  logic adv;
  logic grant;

  // The whole pipe moves together when the output slot is free or drained
  assign adv   = !s2_v_q || resp_ready;
  assign grant = s1_hit_q && rt_live;

  always_comb begin
    s1_v_d     = s1_v_q;
    s1_hit_d   = s1_hit_q;
    s1_ridx_d  = s1_ridx_q;
    s1_dctx_d  = s1_dctx_q;
    s2_v_d     = s2_v_q;
    s2_ok_d    = s2_ok_q;
    s2_route_d = s2_route_q;
    s2_dctx_d  = s2_dctx_q;
    if (adv) begin
      s1_v_d     = req_valid;
      s1_hit_d   = lk_hit;
      s1_ridx_d  = lk_ridx;
      s1_dctx_d  = lk_dctx;
      s2_v_d     = s1_v_q;
      s2_ok_d    = grant;
      s2_route_d = grant ? rt_route  : '0;
      s2_dctx_d  = grant ? s1_dctx_q : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s1_v_q     <= 1'b0;
      s1_hit_q   <= 1'b0;
      s2_v_q     <= 1'b0;
      s2_ok_q    <= 1'b0;
      s2_route_q <= '0;
      s2_dctx_q  <= '0;
    end else begin
      s1_v_q     <= s1_v_d;
      s1_hit_q   <= s1_hit_d;
      s2_v_q     <= s2_v_d;
      s2_ok_q    <= s2_ok_d;
      s2_route_q <= s2_route_d;
      s2_dctx_q  <= s2_dctx_d;
    end
  end

  // Stage 1 payload carries no reset
  always_ff @(posedge clk) begin
    s1_ridx_q <= s1_ridx_d;
    s1_dctx_q <= s1_dctx_d;
  end

  assign req_ready  = adv && rst_core_n;
  assign resp_valid = s2_v_q;
  assign resp_ok    = s2_v_q && s2_ok_q;
  assign resp_exc   = s2_v_q && !s2_ok_q;
  assign resp_route = s2_route_q;
  assign resp_dctx  = s2_dctx_q;

  // R2: accepted request answers two cycles later when the sink is ready
  a_r2_two_cycle: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && req_ready) ##1 resp_ready |=> resp_valid);

  // R9: a stalled response holds still
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_route)
      && $stable(resp_dctx) && $stable(resp_exc)));

  // R8: exception responses carry no translation
  a_r8_exc_blank: assert property (@(posedge clk) disable iff (!rst_core_n)
    (resp_valid && resp_exc) |-> (!resp_ok && resp_route == '0 && resp_dctx == '0));

  // R4: out-of-range context always ends in an exception
  a_r4_range_exc: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && req_ready && ({1'b0, req_ctx} >= (CTX_IN_W+1)'(NUM_CTX)))
      ##1 resp_ready |=> resp_exc);

endmodule

// File: tb/vproc_xlate_test.sv
`timescale 1ns/1ps
module vproc_xlate_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [4:0]  req_ctx;
  logic [5:0]  req_vp;
  logic        resp_valid;
  logic        resp_ready;
  logic        resp_ok;
  logic        resp_exc;
  logic [31:0] resp_route;
  logic [7:0]  resp_dctx;
  logic        wr_en;
  logic [1:0]  wr_kind;
  logic [4:0]  wr_ctx;
  logic [5:0]  wr_idx;
  logic [31:0] wr_data;

  int n_checks = 0;
  int n_fails  = 0;

  vproc_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ctx(req_ctx), .req_vp(req_vp),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_ok(resp_ok), .resp_exc(resp_exc),
    .resp_route(resp_route), .resp_dctx(resp_dctx),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_ctx(wr_ctx), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: {tag[3:0], ctx[4:0], vp[5:0], ok, route[31:0], dctx[7:0]}
  localparam int NVEC = 10;
  localparam logic [55:0] VEC [NVEC] = '{
    {4'd3, 5'd0,  6'd0,  1'b1, 32'h01020304, 8'h11},
    {4'd3, 5'd0,  6'd63, 1'b1, 32'hDEADBEEF, 8'hA5},
    {4'd3, 5'd3,  6'd7,  1'b1, 32'h01020304, 8'h22},
    {4'd3, 5'd15, 6'd2,  1'b1, 32'hDEADBEEF, 8'h33},
    {4'd6, 5'd3,  6'd8,  1'b0, 32'h0,        8'h0},
    {4'd7, 5'd15, 6'd1,  1'b0, 32'h0,        8'h0},
    {4'd5, 5'd2,  6'd4,  1'b0, 32'h0,        8'h0},
    {4'd4, 5'd16, 6'd0,  1'b0, 32'h0,        8'h0},
    {4'd4, 5'd31, 6'd63, 1'b0, 32'h0,        8'h0},
    {4'd6, 5'd0,  6'd1,  1'b0, 32'h0,        8'h0}
  };

  function automatic logic [31:0] entry_word(input logic v, input logic [5:0] ridx,
                                             input logic [7:0] dctx);
    return {v, 17'b0, ridx, dctx};
  endfunction

  function automatic logic [63:0] exp_resp(input logic ok, input logic [31:0] route,
                                           input logic [7:0] dctx);
    return {21'b0, 1'b1, ok, !ok, ok ? route : 32'h0, ok ? dctx : 8'h0};
  endfunction

  function automatic logic [63:0] act_resp();
    return {21'b0, resp_valid, resp_ok, resp_exc, resp_route, resp_dctx};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tbl_write(input logic [1:0] kind, input logic [4:0] c,
                           input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_ctx = c; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue one request and compare the response two cycles later
  task automatic lookup(input string tag, input logic [4:0] c, input logic [5:0] v,
                        input logic ok, input logic [31:0] route, input logic [7:0] dctx);
    @(negedge clk);
    req_valid = 1'b1; req_ctx = c; req_vp = v;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(tag, act_resp(), exp_resp(ok, route, dctx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_ctx = '0; req_vp = '0; resp_ready = 1'b1;
    wr_en = 1'b0; wr_kind = '0; wr_ctx = '0; wr_idx = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle after reset, empty tables deny
    chk("R1 idle", {62'b0, resp_valid, req_ready}, 64'd1);
    lookup("R1 empty tables", 5'd0, 6'd0, 1'b0, 32'h0, 8'h0);

    // Configuration through the write port (R10)
    tbl_write(2'd0, 5'd0,  6'd0, 32'd1);
    tbl_write(2'd0, 5'd3,  6'd0, 32'd1);
    tbl_write(2'd0, 5'd15, 6'd0, 32'd1);
    tbl_write(2'd0, 5'd16, 6'd0, 32'd1);   // out of range, dropped
    tbl_write(2'd1, 5'd0,  6'd0,  entry_word(1'b1, 6'd5,  8'h11));
    tbl_write(2'd1, 5'd0,  6'd63, entry_word(1'b1, 6'd63, 8'hA5));
    tbl_write(2'd1, 5'd3,  6'd7,  entry_word(1'b1, 6'd5,  8'h22));
    tbl_write(2'd1, 5'd3,  6'd8,  entry_word(1'b0, 6'd5,  8'h44));
    tbl_write(2'd1, 5'd15, 6'd1,  entry_word(1'b1, 6'd9,  8'hFF));
    tbl_write(2'd1, 5'd15, 6'd2,  entry_word(1'b1, 6'd63, 8'h33));
    tbl_write(2'd1, 5'd2,  6'd4,  entry_word(1'b1, 6'd5,  8'h55));
    tbl_write(2'd2, 5'd0,  6'd5,  32'h01020304);
    tbl_write(2'd2, 5'd0,  6'd63, 32'hDEADBEEF);
    tbl_write(2'd2, 5'd0,  6'd9,  32'h0A0B0C0D);
    tbl_write(2'd3, 5'd0,  6'd5,  32'd1);
    tbl_write(2'd3, 5'd0,  6'd63, 32'd1);

    // Vector table: R3 grants, R4/R5/R6/R7 denials, R8 blank payload
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d/R8 vector %0d", VEC[i][55:52], i);
      lookup(tag, VEC[i][51:47], VEC[i][46:41], VEC[i][40], VEC[i][39:8], VEC[i][7:0]);
    end

    // R2: back-to-back stream, exact two-cycle latency
    @(negedge clk); req_valid = 1'b1; req_ctx = 5'd0;  req_vp = 6'd0;
    @(negedge clk);
    chk("R2 not yet", {63'b0, resp_valid}, 64'd0);
    req_ctx = 5'd3; req_vp = 6'd7;
    @(negedge clk);
    chk("R2 first", act_resp(), exp_resp(1'b1, 32'h01020304, 8'h11));
    req_ctx = 5'd16; req_vp = 6'd0;
    @(negedge clk);
    chk("R2 second", act_resp(), exp_resp(1'b1, 32'h01020304, 8'h22));
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2 third R4", act_resp(), exp_resp(1'b0, 32'h0, 8'h0));

    // R7: revoke routing entry 5, both contexts using it are denied
    tbl_write(2'd3, 5'd0, 6'd5, 32'd0);
    lookup("R7 revoked ctx0", 5'd0, 6'd0, 1'b0, 32'h0, 8'h0);
    lookup("R7 revoked ctx3", 5'd3, 6'd7, 1'b0, 32'h0, 8'h0);
    tbl_write(2'd3, 5'd0, 6'd5, 32'd1);
    lookup("R7 restored", 5'd0, 6'd0, 1'b1, 32'h01020304, 8'h11);

    // R6: clearing a valid bit denies the next request
    tbl_write(2'd1, 5'd0, 6'd63, entry_word(1'b0, 6'd63, 8'hA5));
    lookup("R6 cleared entry", 5'd0, 6'd63, 1'b0, 32'h0, 8'h0);

    // R11: write in the acceptance cycle does not affect that request
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'd0; wr_ctx = 5'd3; wr_idx = '0; wr_data = 32'd0;
    req_valid = 1'b1; req_ctx = 5'd3; req_vp = 6'd7;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R11 old contents", act_resp(), exp_resp(1'b1, 32'h01020304, 8'h22));
    lookup("R5 disabled ctx", 5'd3, 6'd7, 1'b0, 32'h0, 8'h0);

    // R9: backpressure holds the response and blocks new requests
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_ctx = 5'd15; req_vp = 6'd2;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 presented", act_resp(), exp_resp(1'b1, 32'hDEADBEEF, 8'h33));
    chk("R9 ready low", {63'b0, req_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R9 held", act_resp(), exp_resp(1'b1, 32'hDEADBEEF, 8'h33));
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", {62'b0, resp_valid, req_ready}, 64'd1);

    // R1: reset again clears everything
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    lookup("R1 after reset", 5'd0, 6'd0, 1'b0, 32'h0, 8'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule